// File: doc/BRIEF.md
# Dual-Pulse Up/Down Binary Counter with Parallel Load

This block is a small binary counter whose direction is picked by which of two pulse inputs toggles. A low-to-high transition on the count-up input adds one to the value, and a low-to-high transition on the count-down input subtracts one. The value wraps around in both directions. Both pulse inputs are brought into one system clock domain through a synchroniser chain and are then edge-detected. So a count step appears a fixed number of system clocks after the pulse rises.

An asynchronous active-high clear zeroes the value at once. An active-low load copies the data inputs into the value on the next system clock. Two active-low terminal outputs, carry and borrow, let a following stage count on their rising edge. Carry sits low while the value is at its maximum and the count-up input is low. Borrow sits low while the value is zero and the count-down input is low. In normal use the pulse input that is not being driven rests high.

Top module: `updn_pulse_counter`

## Requirements
- R1: A rising transition on `cnt_up` alone increments `q` by one, modulo 2^WIDTH, so 15 steps to 0 at the default width of 4.
- R2: A rising transition on `cnt_dn` alone decrements `q` by one, modulo 2^WIDTH, so 0 steps to 15.
- R3: The step for a rising pulse lands on the third system clock edge after the input changes (SYNC_STAGES+1 edges). A falling transition or a steady level leaves `q` unchanged.
- R4: While `clr` is high, `q` is 0 without waiting for a clock. This overrides load and counting.
- R5: While `load_n` is low and `clr` is low, each system clock copies `din` into `q`, with `din[0]` going to `q[0]` as the LSB. Pulse edges seen during that time are dropped.
- R6: `carry_n` is 0 exactly when `q` is all ones and `cnt_up` is 0; otherwise it is 1.
- R7: `borrow_n` is 0 exactly when `q` is 0 and `cnt_dn` is 0; otherwise it is 1.
- R8: When rising edges of `cnt_up` and `cnt_dn` are detected on the same system clock, `q` is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both pulse inputs |
| clr | input | 1 | Asynchronous clear, active high |
| load_n | input | 1 | Parallel load enable, active low |
| cnt_up | input | 1 | Count-up pulse input, rests high |
| cnt_dn | input | 1 | Count-down pulse input, rests high |
| din | input | WIDTH | Parallel load data, bit 0 is the LSB |
| q | output | WIDTH | Counter value, bit 0 is the LSB |
| carry_n | output | 1 | Terminal-count-up output, active low |
| borrow_n | output | 1 | Terminal-count-down output, active low |

## Verification
Any corruption of the stored value shows on `q` at the next sample after the step that caused it. Through the model it then carries into every later comparison, as well as into the carry and borrow levels. A synchroniser or edge-detector fault shows up in two ways: as a step that lands one clock early or late against the exact three-edge window, or as an extra step when a pulse input falls. Random sequences of pulses, loads, clears and simultaneous edges are checked after every operation, and directed cases hit both wrap points and both terminal outputs.

// File: rtl/updn_pulse_counter.sv
module updn_pulse_counter #(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load_n,
  input  logic             cnt_up,
  input  logic             cnt_dn,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry_n,
  output logic             borrow_n
);

  localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [SYNC_STAGES:0] up_sh, dn_sh;
  logic up_rise, dn_rise;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      up_sh <= '1;
      dn_sh <= '1;
    end else begin
      up_sh <= {up_sh[SYNC_STAGES-1:0], cnt_up};
      dn_sh <= {dn_sh[SYNC_STAGES-1:0], cnt_dn};
    end
  end

  assign up_rise = up_sh[SYNC_STAGES-1] & ~up_sh[SYNC_STAGES];
  assign dn_rise = dn_sh[SYNC_STAGES-1] & ~dn_sh[SYNC_STAGES];

  always_ff @(posedge clk or posedge clr) begin
    if (clr)
      q <= '0;
    else if (!load_n)
      q <= din;
    else if (up_rise && !dn_rise)
      q <= q + ONE;
    else if (dn_rise && !up_rise)
      q <= q - ONE;
  end

  assign carry_n  = ~((q == MAXV) & ~cnt_up);
  assign borrow_n = ~((q == '0) & ~cnt_dn);

  p_inc_r1: assert property (@(posedge clk) disable iff (clr)
    (load_n && up_rise && !dn_rise) |=> (q == $past(q) + ONE));

  p_dec_r2: assert property (@(posedge clk) disable iff (clr)
    (load_n && dn_rise && !up_rise) |=> (q == $past(q) - ONE));

  p_hold_r3: assert property (@(posedge clk) disable iff (clr)
    (load_n && !up_rise && !dn_rise) |=> $stable(q));

  p_clear_r4: assert property (@(posedge clk) clr |-> (q == '0));

  p_load_r5: assert property (@(posedge clk) disable iff (clr)
    !load_n |=> (q == $past(din)));

  p_both_r8: assert property (@(posedge clk) disable iff (clr)
    (load_n && up_rise && dn_rise) |=> $stable(q));

endmodule

// File: tb/test_updn_pulse_counter.sv
module test_updn_pulse_counter;
  localparam int W = 4;

  logic clk = 1'b0;
  logic clr = 1'b1;
  logic load_n = 1'b1;
  logic cnt_up = 1'b1;
  logic cnt_dn = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;
  logic carry_n, borrow_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [W-1:0] exp_q = '0;

  updn_pulse_counter #(.WIDTH(W), .SYNC_STAGES(2)) i_updn_pulse_counter (
    .clk(clk), .clr(clr), .load_n(load_n), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
    .din(din), .q(q), .carry_n(carry_n), .borrow_n(borrow_n)
  );

  always #5 clk = ~clk;

  function automatic logic exp_carry(logic [W-1:0] v, logic up);
    return !((v == {W{1'b1}}) && !up);
  endfunction

  function automatic logic exp_borrow(logic [W-1:0] v, logic dn);
    return !((v == '0) && !dn);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, q, exp_q);
    chk({req, " R6 carry"}, carry_n, exp_carry(exp_q, cnt_up));
    chk({req, " R7 borrow"}, borrow_n, exp_borrow(exp_q, cnt_dn));
  endtask

  task automatic pulse_up();
    @(negedge clk) cnt_up = 1'b0;
    #1 chk_all("R6 up low");
    repeat (4) @(negedge clk);
    chk_all("R3 falling up no step");
    cnt_up = 1'b1;
    repeat (2) @(negedge clk);
    chk_all("R3 up step not early");
    @(negedge clk);
    exp_q = exp_q + 1'b1;
    chk_all("R1 up step");
  endtask

  task automatic pulse_dn();
    @(negedge clk) cnt_dn = 1'b0;
    #1 chk_all("R7 dn low");
    repeat (4) @(negedge clk);
    chk_all("R3 falling dn no step");
    cnt_dn = 1'b1;
    repeat (2) @(negedge clk);
    chk_all("R3 dn step not early");
    @(negedge clk);
    exp_q = exp_q - 1'b1;
    chk_all("R2 dn step");
  endtask

  task automatic pulse_both();
    @(negedge clk) begin cnt_up = 1'b0; cnt_dn = 1'b0; end
    repeat (4) @(negedge clk);
    cnt_up = 1'b1; cnt_dn = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R8 both edges hold");
  endtask

  task automatic do_load(logic [W-1:0] v, bit with_pulse);
    @(negedge clk) begin din = v; load_n = 1'b0; end
    @(negedge clk);
    exp_q = v;
    chk_all("R5 load");
    if (with_pulse) begin
      cnt_up = 1'b0;
      repeat (3) @(negedge clk);
      cnt_up = 1'b1;
      repeat (4) @(negedge clk);
      chk_all("R5 load beats count");
    end
    load_n = 1'b1;
    @(negedge clk);
    chk_all("R5 after load");
  endtask

  task automatic do_clear();
    @(negedge clk) begin clr = 1'b1; load_n = 1'b0; din = {W{1'b1}}; end
    #1 exp_q = '0;
    chk_all("R4 clear async");
    @(negedge clk);
    chk_all("R4 clear beats load");
    load_n = 1'b1;
    clr = 1'b0;
    @(negedge clk);
    chk_all("R4 after clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R4 reset state");
    clr = 1'b0;
    @(negedge clk);
    // directed: up wrap 15 -> 0
    do_load(4'hE, 0);
    pulse_up();
    pulse_up();
    chk("R1 wrap to zero", q, 0);
    // down wrap 0 -> 15
    pulse_dn();
    chk("R2 wrap to max", q, 4'hF);
    // carry low at max with up low
    @(negedge clk) cnt_up = 1'b0;
    #1 chk("R6 carry low at max", carry_n, 1'b0);
    @(negedge clk) cnt_up = 1'b1;
    repeat (4) @(negedge clk);
    exp_q = exp_q + 1'b1;
    chk_all("R1 carry release step");
    @(negedge clk) cnt_dn = 1'b0;
    #1 chk("R7 borrow low at zero", borrow_n, 1'b0);
    @(negedge clk) cnt_dn = 1'b1;
    repeat (4) @(negedge clk);
    exp_q = exp_q - 1'b1;
    chk_all("R2 borrow release step");
    do_load(4'h5, 1);
    pulse_both();
    pulse_up();
    do_clear();
    // random phase
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 250; i++) begin
      case ($urandom % 6)
        0, 1: pulse_up();
        2, 3: pulse_dn();
        4: do_load(W'($urandom), ($urandom % 2) == 1);
        default: if (($urandom % 3) == 0) do_clear(); else pulse_both();
      endcase
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule